// File: doc/BRIEF.md
# Audio PWM DAC Modulator

This block turns 16-bit PCM audio into one pulse-width-modulated bit stream per channel, to be smoothed by an external low-pass filter. A single-entry sample buffer accepts either one mono word or one 32-bit word that packs a left and a right sample. A control word selects the PWM resolution, the pulse alignment, how many PWM periods each sample is held, the sample format, a left shift and a channel swap.

Each sample is first converted (optional MSB inversion, which maps two's-complement data to offset binary), then shifted left. Its top 8 or 10 bits become the duty value D, and the output is high for D core clocks in every period of 256 or 1024 clocks. A new sample is taken from the buffer only at the end of the N-th period. If the buffer is empty at that point, the previous duty value is played again and an underrun flag is raised.

Top module: `pwm_audio_dac`

## Requirements
- R1: After reset both PWM outputs and `underrun_o` are low, and the control word is all zero, so the block is disabled.
- R2: Control bit 0 enables modulation. While it is clear, both outputs are low from the second clock edge after the clear, and the period and repeat counters are held at zero. On the first edge after the control write that sets it, the buffer is loaded, and the next cycle is count 0 of a new period.
- R3: Control bit 1 selects the resolution: 0 gives a 256-clock period and an 8-bit duty, 1 gives a 1024-clock period and a 10-bit duty. The duty is the top 8 or 10 bits of the formatted sample, and each period has exactly that many high cycles.
- R4: Control bits 3:2 select the alignment. 0 is left (high while count < D). 1 is right (high while count >= P-D). 2 is center (high from count floor((P-D)/2) for D counts). 3 behaves as left.
- R5: Control bits 12:4 hold N-1. Each sample is held for N periods, and the next one is taken at the end of the N-th period.
- R6: When control bit 14 is 1, the sample MSB (bit 15) is inverted before shifting. When it is 0, the sample is used unchanged.
- R7: Control bits 17:15 give a left shift of 0 to 7, applied after the MSB inversion. Bits shifted out of bit 15 are lost.
- R8: With `smp_wide_i` low, bits 15:0 of the word drive both outputs. With it high, bits 15:0 drive the left output and bits 31:16 drive the right output.
- R9: Control bit 13, in stereo mode, exchanges the two halves between the outputs. In mono mode it has no effect.
- R10: If the buffer is empty at a load point, the previous duty values are kept and `underrun_o` goes high. It stays high until a load finds a sample, or until modulation is disabled.
- R11: The buffer holds one word. A write replaces any sample not yet consumed. A write in the same cycle as a load is kept for the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; one PWM count per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_i | input | 18 | Control word |
| smp_we_i | input | 1 | Sample buffer write strobe |
| smp_wide_i | input | 1 | 1: word packs two channels; 0: mono in bits 15:0 |
| smp_i | input | 32 | Sample word |
| pwm_l_o | output | 1 | Left channel PWM bit |
| pwm_r_o | output | 1 | Right channel PWM bit |
| underrun_o | output | 1 | Last load found the buffer empty |

## Verification
Whole periods are captured bit by bit and compared with the pattern expected for each alignment. This separates a correct high-cycle count in the wrong place from a wrong count. Directed words cover the extremes: duty of half scale, full scale 255 in right alignment, a shifted sample in 10-bit center mode, and the reserved alignment code. A stereo word with distinct halves and swap set shows whether lanes are steered correctly, and a mono word with swap set shows that swap is ignored there. A three-period repeat run with a write landing on the load edge, followed by an empty buffer, separates hold length, write-wins-over-consume and underrun repetition. Random words, shifts, formats and resolutions then cover the remaining combinations.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int SAMPLE_W = 16;
  localparam int RES_LO   = 8;
  localparam int RES_HI   = 10;
  localparam int REP_W    = 9;
  localparam int SHF_W    = 3;
  localparam int CTRL_W   = SHF_W + 1 + 1 + REP_W + 2 + 1 + 1;

  typedef enum logic [1:0] {
    ALIGN_LEFT   = 2'd0,
    ALIGN_RIGHT  = 2'd1,
    ALIGN_CENTER = 2'd2,
    ALIGN_RSVD   = 2'd3
  } align_e;

  // field order fixes the bit positions of the control word
  typedef struct packed {
    logic [SHF_W-1:0] shamt;
    logic             msb_inv;
    logic             swap;
    logic [REP_W-1:0] rep_m1;
    align_e           align;
    logic             res_hi;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/pwm_dac_fmt.sv
module pwm_dac_fmt #(
  parameter int SAMPLE_W = 16,
  parameter int RES_LO   = 8,
  parameter int RES_HI   = 10,
  parameter int SHF_W    = 3
) (
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                msb_inv_i,
  input  logic [SHF_W-1:0]    shamt_i,
  input  logic                res_hi_i,
  output logic [RES_HI-1:0]   duty_o
);
  localparam int PAD_W = RES_HI - RES_LO;

  logic [SAMPLE_W-1:0] conv, shifted;

  always_comb begin
    conv    = smp_i ^ {msb_inv_i, {(SAMPLE_W-1){1'b0}}};
    shifted = conv << shamt_i;
    if (res_hi_i) duty_o = shifted[SAMPLE_W-1 -: RES_HI];
    else          duty_o = {{PAD_W{1'b0}}, shifted[SAMPLE_W-1 -: RES_LO]};
  end
endmodule

// File: rtl/pwm_dac_timebase.sv
module pwm_dac_timebase #(
  parameter int CNT_W = 10,
  parameter int LO_W  = 8,
  parameter int REP_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             res_hi_i,
  input  logic [REP_W-1:0] rep_m1_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_last_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] LAST_HI = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'((1 << LO_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [REP_W-1:0] rep_q;
  logic             run_q;
  logic             rep_last;

  // >= keeps the wrap safe when resolution drops mid-period
  assign cnt_last_o = cnt_q >= (res_hi_i ? LAST_HI : LAST_LO);
  assign rep_last   = rep_q >= rep_m1_i;
  assign load_o     = en_i && (!run_q || (cnt_last_o && rep_last));
  assign run_o      = run_q;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      rep_q <= '0;
    end else begin
      run_q <= en_i;
      if (!en_i || !run_q) begin
        cnt_q <= '0;
        rep_q <= '0;
      end else if (cnt_last_o) begin
        cnt_q <= '0;
        rep_q <= rep_last ? '0 : rep_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_dac_cmp.sv
module pwm_dac_cmp
  import pwm_dac_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LO_W  = 8
) (
  input  logic             run_i,
  input  logic             res_hi_i,
  input  align_e           align_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  localparam int PW = CNT_W + 1;

  logic [PW-1:0] per, gap, lead, cnt_x, duty_x;
  logic          hit;

  always_comb begin
    per    = res_hi_i ? PW'(1) << CNT_W : PW'(1) << LO_W;
    duty_x = {1'b0, duty_i};
    cnt_x  = {1'b0, cnt_i};
    gap    = per - duty_x;
    lead   = gap >> 1;
    unique case (align_i)
      ALIGN_RIGHT:  hit = cnt_x >= gap;
      ALIGN_CENTER: hit = (cnt_x >= lead) && (cnt_x < lead + duty_x);
      default:      hit = cnt_x < duty_x;
    endcase
    pwm_o = run_i & hit;
  end
endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
  import pwm_dac_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  input  logic                smp_we_i,
  input  logic                smp_wide_i,
  input  logic [2*SAMPLE_W-1:0] smp_i,
  output logic                pwm_l_o,
  output logic                pwm_r_o,
  output logic                underrun_o
);
  localparam int NCH = 2;

  ctrl_t                         ctrl_q;
  logic [2*SAMPLE_W-1:0]         buf_q;
  logic                          buf_valid_q, buf_wide_q;
  logic [NCH-1:0][RES_HI-1:0]    duty_q, duty_new;
  logic [NCH-1:0]                pwm;
  logic                          underrun_q;
  logic                          run, cnt_last, load;
  logic [RES_HI-1:0]             cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_i);
  end

  // single-entry buffer; a write beats a same-cycle consume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q       <= '0;
      buf_wide_q  <= 1'b0;
      buf_valid_q <= 1'b0;
    end else if (smp_we_i) begin
      buf_q       <= smp_i;
      buf_wide_q  <= smp_wide_i;
      buf_valid_q <= 1'b1;
    end else if (load) begin
      buf_valid_q <= 1'b0;
    end
  end

  pwm_dac_timebase #(
    .CNT_W(RES_HI), .LO_W(RES_LO), .REP_W(REP_W)
  ) i_timebase (
    .clk_i, .rst_ni,
    .en_i       (ctrl_q.en),
    .res_hi_i   (ctrl_q.res_hi),
    .rep_m1_i   (ctrl_q.rep_m1),
    .run_o      (run),
    .cnt_o      (cnt),
    .cnt_last_o (cnt_last),
    .load_o     (load)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic IS_R = (ch == 1);
    logic                lane_hi;
    logic [SAMPLE_W-1:0] smp;

    assign lane_hi = buf_wide_q & (ctrl_q.swap ^ IS_R);
    assign smp     = lane_hi ? buf_q[2*SAMPLE_W-1:SAMPLE_W] : buf_q[SAMPLE_W-1:0];

    pwm_dac_fmt #(
      .SAMPLE_W(SAMPLE_W), .RES_LO(RES_LO), .RES_HI(RES_HI), .SHF_W(SHF_W)
    ) i_fmt (
      .smp_i     (smp),
      .msb_inv_i (ctrl_q.msb_inv),
      .shamt_i   (ctrl_q.shamt),
      .res_hi_i  (ctrl_q.res_hi),
      .duty_o    (duty_new[ch])
    );

    pwm_dac_cmp #(.CNT_W(RES_HI), .LO_W(RES_LO)) i_cmp (
      .run_i    (run),
      .res_hi_i (ctrl_q.res_hi),
      .align_i  (ctrl_q.align),
      .cnt_i    (cnt),
      .duty_i   (duty_q[ch]),
      .pwm_o    (pwm[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q     <= '0;
      underrun_q <= 1'b0;
    end else if (!ctrl_q.en) begin
      underrun_q <= 1'b0;
    end else if (load) begin
      if (buf_valid_q) begin
        duty_q     <= duty_new;
        underrun_q <= 1'b0;
      end else begin
        underrun_q <= 1'b1;
      end
    end
  end

  assign pwm_l_o    = pwm[0];
  assign pwm_r_o    = pwm[1];
  assign underrun_o = underrun_q;
endmodule

// File: rtl/pwm_audio_dac_chk.sv
module pwm_audio_dac_chk
  import pwm_dac_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input ctrl_t                  ctrl_q,
  input logic                   load,
  input logic                   buf_valid_q,
  input logic                   buf_wide_q,
  input logic                   smp_we_i,
  input logic [1:0][CNT_W-1:0]  duty_q,
  input logic [CNT_W-1:0]       cnt,
  input logic                   run,
  input logic                   cnt_last,
  input logic                   pwm_l_o,
  input logic                   pwm_r_o,
  input logic                   underrun_o
);
  a_r2_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |=> (!pwm_l_o && !pwm_r_o));

  a_r3_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && run && !cnt_last) |=> (cnt == $past(cnt) + 1'b1));

  a_r8_mono_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && buf_valid_q && !buf_wide_q) |=> (duty_q[0] == duty_q[1]));

  a_r10_underrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !buf_valid_q) |=> (underrun_o && $stable(duty_q)));

  a_r11_consume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && buf_valid_q && !smp_we_i) |=> !buf_valid_q);

  a_r11_write_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_we_i |=> buf_valid_q);
endmodule

bind pwm_audio_dac pwm_audio_dac_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_q      (ctrl_q),
  .load        (load),
  .buf_valid_q (buf_valid_q),
  .buf_wide_q  (buf_wide_q),
  .smp_we_i    (smp_we_i),
  .duty_q      (duty_q),
  .cnt         (cnt),
  .run         (run),
  .cnt_last    (cnt_last),
  .pwm_l_o     (pwm_l_o),
  .pwm_r_o     (pwm_r_o),
  .underrun_o  (underrun_o)
);

// File: tb/test_pwm_audio_dac.sv
module test_pwm_audio_dac;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0, smp_we_i = 1'b0, smp_wide_i = 1'b0;
  logic [17:0] ctrl_i = '0;
  logic [31:0] smp_i = '0;
  logic        pwm_l_o, pwm_r_o, underrun_o;
  int          checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_audio_dac i_pwm_audio_dac (.*);

  function automatic int fmt(input logic [15:0] s, input bit inv, input int sh, input bit hi);
    logic [15:0] c;
    c = s ^ (inv ? 16'h8000 : 16'h0000);
    c = c << sh;
    return hi ? int'(c[15:6]) : int'(c[15:8]);
  endfunction

  function automatic bit exp_bit(input int j, input int d, input int per, input int al);
    int lead;
    lead = (per - d) / 2;
    case (al)
      1:       return j >= per - d;
      2:       return (j >= lead) && (j < lead + d);
      default: return j < d;
    endcase
  endfunction

  function automatic logic [17:0] cw(input bit en, input bit hi, input int al, input int rep_m1,
                                     input bit swap, input bit inv, input int sh);
    return {3'(sh), inv, swap, 9'(rep_m1), 2'(al), hi, en};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr_ctrl(input logic [17:0] v);
    ctrl_we_i = 1'b1; ctrl_i = v;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic wr_smp(input logic [31:0] v, input bit wide);
    smp_we_i = 1'b1; smp_i = v; smp_wide_i = wide;
    @(negedge clk_i);
    smp_we_i = 1'b0;
  endtask

  // called at count 0; compares one full period on both outputs
  task automatic check_period(input int per, input int dl, input int dr, input int al, input string req);
    int bad_l = 0, bad_r = 0, hl = 0, hr = 0;
    for (int j = 0; j < per; j++) begin
      hl += int'(pwm_l_o);
      hr += int'(pwm_r_o);
      if (pwm_l_o !== exp_bit(j, dl, per, al)) bad_l++;
      if (pwm_r_o !== exp_bit(j, dr, per, al)) bad_r++;
      @(negedge clk_i);
    end
    check(bad_l == 0, {req, " left high count"}, hl, dl);
    check(bad_r == 0, {req, " right high count"}, hr, dr);
  endtask

  // program a disabled config, load one word, then enable; ends at count 0
  task automatic start_case(input logic [17:0] cfg, input logic [31:0] w, input bit wide);
    wr_ctrl(cfg & ~18'h1);
    wr_smp(w, wide);
    check(!pwm_l_o && !pwm_r_o, "R2 disabled outputs low", int'(pwm_l_o | pwm_r_o), 0);
    wr_ctrl(cfg | 18'h1);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int d, dl, dr, per, al, sh;
    bit hi, inv, swap, wide;
    logic [31:0] w;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    check(!pwm_l_o && !pwm_r_o, "R1 outputs low after reset", int'(pwm_l_o | pwm_r_o), 0);
    check(!underrun_o, "R1 underrun low after reset", int'(underrun_o), 0);
    repeat (300) @(negedge clk_i);
    check(!pwm_l_o && !pwm_r_o, "R1 stays disabled", int'(pwm_l_o | pwm_r_o), 0);

    // R3 R6 R8: half scale via MSB inversion, mono drives both
    start_case(cw(1, 0, 0, 0, 0, 1, 0), 32'h5555_0000, 0);
    check_period(256, 128, 128, 0, "R3/R6/R8 mono half scale");

    // R4: right aligned full scale
    start_case(cw(1, 0, 1, 0, 0, 0, 0), 32'h0000_FFFF, 0);
    check_period(256, 255, 255, 1, "R4 right full scale");

    // R4 R7: 10-bit center with shift 3
    d = fmt(16'h0123, 0, 3, 1);
    start_case(cw(1, 1, 2, 0, 0, 0, 3), 32'h0000_0123, 0);
    check_period(1024, d, d, 2, "R4/R7 center 10-bit shifted");

    // R4: code 3 acts as left
    start_case(cw(1, 0, 3, 0, 0, 0, 0), 32'h0000_6100, 0);
    check_period(256, 8'h61, 8'h61, 0, "R4 reserved code left");

    // R9: swap ignored in mono
    start_case(cw(1, 0, 0, 0, 1, 0, 0), 32'hF000_3400, 0);
    check_period(256, 8'h34, 8'h34, 0, "R9 mono swap ignored");

    // R8 R9: stereo lanes, swap set
    start_case(cw(1, 0, 0, 0, 1, 0, 0), 32'h2000_A000, 1);
    check_period(256, 8'h20, 8'hA0, 0, "R8/R9 stereo swapped");

    // R11: second write replaces unconsumed sample
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0));
    wr_smp(32'h0000_1100, 0);
    wr_smp(32'h0000_7700, 0);
    wr_ctrl(cw(1, 0, 0, 0, 0, 0, 0));
    @(negedge clk_i);
    check_period(256, 8'h77, 8'h77, 0, "R11 last write wins");

    // R5 R10 R11: hold 3 periods, write on load edge, then underrun
    wr_ctrl(cw(0, 0, 0, 2, 0, 0, 0));
    wr_smp(32'h0000_4000, 0);
    wr_ctrl(cw(1, 0, 0, 2, 0, 0, 0));
    wr_smp(32'h0000_C000, 0);
    for (int p = 0; p < 3; p++) check_period(256, 64, 64, 0, "R5 first sample held");
    check(!underrun_o, "R11 write on load edge kept", int'(underrun_o), 0);
    for (int p = 0; p < 3; p++) check_period(256, 192, 192, 0, "R5/R11 second sample held");
    check(underrun_o, "R10 underrun raised", int'(underrun_o), 1);
    check_period(256, 192, 192, 0, "R10 previous duty repeated");
    wr_ctrl(cw(0, 0, 0, 0, 0, 0, 0));
    @(negedge clk_i);
    check(!underrun_o, "R10 cleared by disable", int'(underrun_o), 0);

    // random mix
    for (int i = 0; i < 24; i++) begin
      w    = $urandom;
      hi   = 1'($urandom);
      al   = int'($urandom % 4);
      sh   = int'($urandom % 8);
      inv  = 1'($urandom);
      swap = 1'($urandom);
      wide = 1'($urandom);
      per  = hi ? 1024 : 256;
      if (!wide)     begin dl = fmt(w[15:0], inv, sh, hi);  dr = dl; end
      else if (swap) begin dl = fmt(w[31:16], inv, sh, hi); dr = fmt(w[15:0], inv, sh, hi); end
      else           begin dl = fmt(w[15:0], inv, sh, hi);  dr = fmt(w[31:16], inv, sh, hi); end
      start_case(cw(1, hi, al, 0, swap, inv, sh), w, wide);
      check_period(per, dl, dr, al, "R3/R4/R6/R7/R8/R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule